// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Unit

This unit runs the two reservation-based atomic instructions of a RISC-style integer core: the reserving load and the conditional store. The pipeline hands it one operation at a time: the opcode (reserve-load or conditional-store), an access size, a base address, the source data for a store and a destination register index. The unit checks the address alignment and holds one reservation (address, size and a valid bit). It talks to memory over a single request/response port. Address translation and access faults arrive as a fault flag on the memory response.

A conditional store never faults just because it loses. If no matching reservation is held, the store returns 1 and memory is not touched. If the store reaches memory, it returns 0 when memory accepts the write and 1 when memory refuses it. In both cases the reservation is dropped. Exceptions come back as a cause code with no register write-back. An external invalidate input drops the reservation, for example on a conflicting write seen elsewhere.

Top module: `lrsc_unit`

## Requirements
- R1: The size code is 0 for byte, 1 for halfword, 2 for word and 3 for doubleword. A byte access is always aligned. A halfword needs address bit 0 clear. A word needs bits 1:0 clear. A doubleword needs bits 2:0 clear.
- R2: A misaligned reserving load ends with cause 4 and a misaligned conditional store ends with cause 6. Neither issues a memory request nor writes back a register.
- R3: A faulting memory response ends a reserving load with cause 5 and a conditional store with cause 7, with no write-back and no change to the reservation.
- R4: A conditional store that finds no valid reservation with the same address and size writes back 1, issues no memory request and leaves the reservation invalid.
- R5: A conditional store that reaches memory writes back 0 if the response is not refused and 1 if it is refused. The reservation is invalid afterwards in both cases.
- R6: A conditional store request carries `mem_req_write`=1 and the operation's size. A word store carries only the low 32 source bits, with the upper bits zero. A doubleword store carries the full source.
- R7: When XLEN is 32, any doubleword operation ends with cause 2 and issues no memory request.
- R8: Load data arrives right-justified. Byte, halfword and word loads are sign-extended to XLEN. A doubleword load is returned unchanged.
- R9: A reserving load that completes without fault makes the reservation valid for its aligned address and size. A later store matches only when both the address and the size are equal.
- R10: `resv_inval` drops the reservation. It takes priority over a reserving load that completes in the same cycle.
- R11: Out of reset the unit is idle with no request or result. `mem_req_valid` and its fields hold steady until `mem_req_ready`. `busy` stays high from acceptance until the result.
- R12: An outcome decided without memory appears on `done_valid` one cycle after the operation is accepted. A memory outcome appears one cycle after the response is taken. `done_rd` echoes the destination index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered; accepted when not busy |
| op_is_sc | input | 1 | 1 = conditional store, 0 = reserving load |
| op_size | input | 2 | Access size code |
| op_addr | input | XLEN | Effective address |
| op_src | input | XLEN | Store source data |
| op_rd | input | RD_W | Destination register index |
| busy | output | 1 | Operation in flight |
| resv_inval | input | 1 | Drop the reservation |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | Request is a write |
| mem_req_addr | output | XLEN | Request address |
| mem_req_size | output | 2 | Request size code |
| mem_req_wdata | output | XLEN | Write data |
| mem_rsp_valid | input | 1 | Response valid |
| mem_rsp_data | input | XLEN | Read data, right-justified |
| mem_rsp_fault | input | 1 | Translation or access fault |
| mem_rsp_refused | input | 1 | Store refused by memory |
| done_valid | output | 1 | Result valid for one cycle |
| done_wb_en | output | 1 | Write back to register file |
| done_rd | output | RD_W | Destination index |
| done_wb_data | output | XLEN | Write-back value |
| done_exc | output | 1 | Exception raised |
| done_cause | output | 5 | Exception cause |

## Verification
Alignment, illegal-size and lost-reservation outcomes are due on the falling edge that follows the rising edge that accepted the operation. Memory outcomes are due on the falling edge that follows the rising edge on which the response was taken. The bench drives each input on a falling edge and reads each result exactly one falling edge later. A missing `done_valid` at that point therefore counts as a miscompare, not as a reason to wait. Each memory operation also holds `mem_req_ready` low for one extra cycle, so the bench can check that the request stays steady before it is accepted.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_H = 2'd1;
  localparam logic [1:0] SZ_W = 2'd2;
  localparam logic [1:0] SZ_D = 2'd3;

  localparam logic [4:0] CAUSE_ILLEGAL   = 5'd2;
  localparam logic [4:0] CAUSE_LD_ALIGN  = 5'd4;
  localparam logic [4:0] CAUSE_LD_FAULT  = 5'd5;
  localparam logic [4:0] CAUSE_ST_ALIGN  = 5'd6;
  localparam logic [4:0] CAUSE_ST_FAULT  = 5'd7;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} lrsc_state_e;

  // Low address bits that must be zero for a given size code.
  function automatic logic [2:0] low_mask(input logic [1:0] sz);
    case (sz)
      SZ_B:    return 3'b000;
      SZ_H:    return 3'b001;
      SZ_W:    return 3'b011;
      default: return 3'b111;
    endcase
  endfunction

  function automatic logic addr_aligned(input logic [2:0] lo, input logic [1:0] sz);
    return (lo & low_mask(sz)) == 3'b000;
  endfunction
endpackage

// File: rtl/lrsc_addr_check.sv
module lrsc_addr_check
  import lrsc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [1:0] size,
  input  logic [2:0] addr_lo,
  output logic       misaligned,
  output logic       illegal
);
  localparam bit HAS_DOUBLE = (XLEN >= 64);

  assign misaligned = !addr_aligned(addr_lo, size);
  assign illegal    = !HAS_DOUBLE && (size == SZ_D);
endmodule

// File: rtl/lrsc_resv.sv
module lrsc_resv
  import lrsc_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [AW-1:0] set_addr,
  input  logic [1:0]    set_size,
  input  logic          drop_en,
  input  logic          inval,
  input  logic [AW-1:0] chk_addr,
  input  logic [1:0]    chk_size,
  output logic          hit,
  output logic          valid
);
  logic [AW-1:0] r_addr;
  logic [1:0]    r_size;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      r_addr <= '0;
      r_size <= SZ_B;
    end else if (inval) begin
      valid <= 1'b0;
    end else if (set_en) begin
      valid  <= 1'b1;
      r_addr <= set_addr & ~AW'(low_mask(set_size));
      r_size <= set_size;
    end else if (drop_en) begin
      valid <= 1'b0;
    end
  end

  assign hit = valid && (chk_addr == r_addr) && (chk_size == r_size);
endmodule

// File: rtl/lrsc_data_fmt.sv
module lrsc_data_fmt
  import lrsc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [1:0]      ld_size,
  input  logic [XLEN-1:0] ld_raw,
  output logic [XLEN-1:0] ld_ext,
  input  logic [1:0]      st_size,
  input  logic [XLEN-1:0] st_raw,
  output logic [XLEN-1:0] st_fmt
);
  function automatic logic [XLEN-1:0] sext(input logic [XLEN-1:0] d, input logic [1:0] sz);
    int unsigned bits;
    bits = 32'd8 << sz;
    if (bits >= XLEN) return d;
    return XLEN'($signed(d << (XLEN - bits)) >>> (XLEN - bits));
  endfunction

  function automatic logic [XLEN-1:0] zfit(input logic [XLEN-1:0] d, input logic [1:0] sz);
    int unsigned bits;
    bits = 32'd8 << sz;
    if (bits >= XLEN) return d;
    return d & ~({XLEN{1'b1}} << bits);
  endfunction

  assign ld_ext = sext(ld_raw, ld_size);
  assign st_fmt = zfit(st_raw, st_size);
endmodule

// File: rtl/lrsc_unit.sv
module lrsc_unit
  import lrsc_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int RD_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic            op_is_sc,
  input  logic [1:0]      op_size,
  input  logic [XLEN-1:0] op_addr,
  input  logic [XLEN-1:0] op_src,
  input  logic [RD_W-1:0] op_rd,
  output logic            busy,
  input  logic            resv_inval,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_write,
  output logic [XLEN-1:0] mem_req_addr,
  output logic [1:0]      mem_req_size,
  output logic [XLEN-1:0] mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic [XLEN-1:0] mem_rsp_data,
  input  logic            mem_rsp_fault,
  input  logic            mem_rsp_refused,
  output logic            done_valid,
  output logic            done_wb_en,
  output logic [RD_W-1:0] done_rd,
  output logic [XLEN-1:0] done_wb_data,
  output logic            done_exc,
  output logic [4:0]      done_cause
);
  lrsc_state_e     state;
  logic            lat_sc;
  logic [1:0]      lat_size;
  logic [XLEN-1:0] lat_addr;
  logic [XLEN-1:0] lat_src;
  logic [RD_W-1:0] lat_rd;
  logic            done_sc;

  // Named internal events, also used by the checker.
  logic accept, misaligned, illegal, resv_hit, resv_valid;
  logic imm_exc, imm_miss, go_mem, rsp_take, resv_set, resv_drop;
  logic [XLEN-1:0] ld_ext, st_fmt;

  lrsc_addr_check #(.XLEN(XLEN)) u_chk_addr (
    .size(op_size), .addr_lo(op_addr[2:0]),
    .misaligned(misaligned), .illegal(illegal)
  );

  lrsc_resv #(.AW(XLEN)) u_resv (
    .clk(clk), .rst_n(rst_n),
    .set_en(resv_set), .set_addr(lat_addr), .set_size(lat_size),
    .drop_en(resv_drop), .inval(resv_inval),
    .chk_addr(op_addr), .chk_size(op_size),
    .hit(resv_hit), .valid(resv_valid)
  );

  lrsc_data_fmt #(.XLEN(XLEN)) u_fmt (
    .ld_size(lat_size), .ld_raw(mem_rsp_data), .ld_ext(ld_ext),
    .st_size(lat_size), .st_raw(lat_src), .st_fmt(st_fmt)
  );

  assign busy      = (state != ST_IDLE);
  assign accept    = op_valid && (state == ST_IDLE);
  assign imm_exc   = accept && (illegal || misaligned);
  assign imm_miss  = accept && !imm_exc && op_is_sc && !resv_hit;
  assign go_mem    = accept && !imm_exc && !imm_miss;
  assign rsp_take  = (state == ST_WAIT) && mem_rsp_valid;
  assign resv_set  = rsp_take && !lat_sc && !mem_rsp_fault;
  assign resv_drop = imm_miss || (rsp_take && lat_sc && !mem_rsp_fault);

  assign mem_req_valid = (state == ST_REQ);
  assign mem_req_write = lat_sc;
  assign mem_req_addr  = lat_addr;
  assign mem_req_size  = lat_size;
  assign mem_req_wdata = st_fmt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      lat_sc   <= 1'b0;
      lat_size <= SZ_B;
      lat_addr <= '0;
      lat_src  <= '0;
      lat_rd   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (go_mem) state <= ST_REQ;
        ST_REQ:  if (mem_req_ready) state <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
      if (accept) begin
        lat_sc   <= op_is_sc;
        lat_size <= op_size;
        lat_addr <= op_addr;
        lat_src  <= op_src;
        lat_rd   <= op_rd;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_valid   <= 1'b0;
      done_wb_en   <= 1'b0;
      done_rd      <= '0;
      done_wb_data <= '0;
      done_exc     <= 1'b0;
      done_cause   <= '0;
      done_sc      <= 1'b0;
    end else begin
      done_valid <= 1'b0;
      done_wb_en <= 1'b0;
      done_exc   <= 1'b0;
      if (imm_exc) begin
        done_valid <= 1'b1;
        done_exc   <= 1'b1;
        done_rd    <= op_rd;
        done_sc    <= op_is_sc;
        done_cause <= illegal ? CAUSE_ILLEGAL
                    : (op_is_sc ? CAUSE_ST_ALIGN : CAUSE_LD_ALIGN);
      end else if (imm_miss) begin
        done_valid   <= 1'b1;
        done_wb_en   <= 1'b1;
        done_rd      <= op_rd;
        done_sc      <= 1'b1;
        done_wb_data <= XLEN'(1);
      end else if (rsp_take) begin
        done_valid <= 1'b1;
        done_rd    <= lat_rd;
        done_sc    <= lat_sc;
        if (mem_rsp_fault) begin
          done_exc   <= 1'b1;
          done_cause <= lat_sc ? CAUSE_ST_FAULT : CAUSE_LD_FAULT;
        end else begin
          done_wb_en   <= 1'b1;
          done_wb_data <= lat_sc ? XLEN'(mem_rsp_refused) : ld_ext;
        end
      end
    end
  end
endmodule

// File: rtl/lrsc_unit_chk.sv
module lrsc_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            imm_exc,
  input logic            imm_miss,
  input logic            busy,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [XLEN-1:0] mem_req_addr,
  input logic [XLEN-1:0] mem_req_wdata,
  input logic            done_valid,
  input logic            done_exc,
  input logic            done_wb_en,
  input logic [XLEN-1:0] done_wb_data,
  input logic            done_sc,
  input logic            resv_valid,
  input logic            resv_inval
);
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata));

  p_req_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  p_imm_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    imm_exc || imm_miss |=> done_valid && !mem_req_valid);

  p_exc_no_wb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_exc |-> !done_wb_en);

  p_sc_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    imm_miss |=> done_wb_en && (done_wb_data == XLEN'(1)) && !resv_valid);

  p_sc_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && done_sc && done_wb_en |-> !resv_valid);

  p_lr_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !done_sc && !done_exc && !$past(resv_inval) |-> resv_valid);
endmodule

bind lrsc_unit lrsc_unit_chk #(.XLEN(XLEN)) u_lrsc_chk (
  .clk(clk), .rst_n(rst_n), .imm_exc(imm_exc), .imm_miss(imm_miss), .busy(busy),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
  .done_valid(done_valid), .done_exc(done_exc), .done_wb_en(done_wb_en),
  .done_wb_data(done_wb_data), .done_sc(done_sc),
  .resv_valid(resv_valid), .resv_inval(resv_inval)
);

// File: tb/lrsc_unit_tb.sv
module lrsc_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0, op_is_sc = 1'b0;
  logic [1:0]  op_size = 2'd0;
  logic [63:0] op_addr = '0, op_src = '0;
  logic [4:0]  op_rd = '0;
  logic        busy, resv_inval = 1'b0;
  logic        mem_req_valid, mem_req_ready = 1'b0, mem_req_write;
  logic [63:0] mem_req_addr, mem_req_wdata;
  logic [1:0]  mem_req_size;
  logic        mem_rsp_valid = 1'b0, mem_rsp_fault = 1'b0, mem_rsp_refused = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        done_valid, done_wb_en, done_exc;
  logic [4:0]  done_rd, done_cause;
  logic [63:0] done_wb_data;

  // 32-bit variant, used only for the doubleword-illegal case.
  logic        op32_valid = 1'b0;
  logic        b32, m32v, m32w, d32v, d32wb, d32e;
  logic [31:0] m32a, m32d, d32data;
  logic [1:0]  m32s;
  logic [4:0]  d32rd, d32c;

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  // Results of the last operation.
  logic        r_done, r_mem, r_exc, r_wb_en, r_write;
  logic [4:0]  r_cause, r_rd;
  logic [63:0] r_wb, r_wdata;
  logic [1:0]  r_size;

  always #10 clk = ~clk;

  lrsc_unit #(.XLEN(64), .RD_W(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_is_sc(op_is_sc), .op_size(op_size),
    .op_addr(op_addr), .op_src(op_src), .op_rd(op_rd), .busy(busy), .resv_inval(resv_inval),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_size(mem_req_size), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_fault(mem_rsp_fault),
    .mem_rsp_refused(mem_rsp_refused), .done_valid(done_valid), .done_wb_en(done_wb_en),
    .done_rd(done_rd), .done_wb_data(done_wb_data), .done_exc(done_exc), .done_cause(done_cause)
  );

  lrsc_unit #(.XLEN(32), .RD_W(5)) u_dut32 (
    .clk(clk), .rst_n(rst_n), .op_valid(op32_valid), .op_is_sc(1'b0), .op_size(2'd3),
    .op_addr(32'h8), .op_src(32'h0), .op_rd(5'd9), .busy(b32), .resv_inval(1'b0),
    .mem_req_valid(m32v), .mem_req_ready(1'b0), .mem_req_write(m32w),
    .mem_req_addr(m32a), .mem_req_size(m32s), .mem_req_wdata(m32d),
    .mem_rsp_valid(1'b0), .mem_rsp_data(32'h0), .mem_rsp_fault(1'b0),
    .mem_rsp_refused(1'b0), .done_valid(d32v), .done_wb_en(d32wb),
    .done_rd(d32rd), .done_wb_data(d32data), .done_exc(d32e), .done_cause(d32c)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // One operation: immediate outcomes are read one falling edge after issue;
  // memory operations stall ready for a cycle, then respond.
  task automatic do_op(input logic sc, input logic [1:0] sz, input logic [63:0] addr,
                       input logic [63:0] src, input logic [4:0] rd,
                       input logic fault, input logic refused, input logic [63:0] rdata,
                       input logic inval_rsp);
    @(negedge clk);
    op_valid = 1'b1; op_is_sc = sc; op_size = sz; op_addr = addr; op_src = src; op_rd = rd;
    @(negedge clk);
    op_valid = 1'b0;
    r_mem = mem_req_valid;
    if (done_valid || !mem_req_valid) begin
      r_done = done_valid;
    end else begin
      r_write = mem_req_write; r_size = mem_req_size; r_wdata = mem_req_wdata;
      @(negedge clk);
      chk("R11", "request held while not ready", {mem_req_valid, mem_req_addr == addr}, 2'b11);
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b1; mem_rsp_fault = fault; mem_rsp_refused = refused;
      mem_rsp_data = rdata; resv_inval = inval_rsp;
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_fault = 1'b0; mem_rsp_refused = 1'b0; resv_inval = 1'b0;
      r_done = done_valid;
    end
    r_exc = done_exc; r_cause = done_cause; r_wb_en = done_wb_en; r_wb = done_wb_data; r_rd = done_rd;
  endtask

  task automatic t_reset();
    chk("R11", "busy after reset", busy, 0);
    chk("R11", "done after reset", done_valid, 0);
    chk("R11", "mem req after reset", mem_req_valid, 0);
  endtask

  task automatic t_align();
    do_op(0, 2'd1, 64'h101, 0, 5'd1, 0, 0, 0, 0);
    chk("R2", "LR half misaligned", {r_done, r_mem, r_exc, r_wb_en, r_cause}, {4'b1010, 5'd4});
    do_op(0, 2'd2, 64'h102, 0, 5'd1, 0, 0, 0, 0);
    chk("R1", "LR word bit1 set", {r_done, r_mem, r_exc, r_cause}, {3'b101, 5'd4});
    do_op(0, 2'd3, 64'h104, 0, 5'd1, 0, 0, 0, 0);
    chk("R1", "LR double bit2 set", {r_done, r_mem, r_exc, r_cause}, {3'b101, 5'd4});
    do_op(1, 2'd2, 64'h006, 0, 5'd2, 0, 0, 0, 0);
    chk("R2", "SC word misaligned", {r_done, r_mem, r_exc, r_wb_en, r_cause}, {4'b1010, 5'd6});
    do_op(1, 2'd1, 64'h001, 0, 5'd2, 0, 0, 0, 0);
    chk("R2", "SC half misaligned", {r_done, r_exc, r_cause}, {2'b11, 5'd6});
    do_op(0, 2'd0, 64'h103, 0, 5'd3, 0, 0, 64'h80, 0);
    chk("R1", "LR byte odd address reaches memory", {r_mem, r_exc}, 2'b10);
    chk("R8", "LR byte sign extension", r_wb, 64'hFFFF_FFFF_FFFF_FF80);
  endtask

  task automatic t_sc_success();
    do_op(0, 2'd2, 64'h400, 0, 5'd7, 0, 0, 64'h0000_0000_8000_0001, 0);
    chk("R8", "LR word sign extension", r_wb, 64'hFFFF_FFFF_8000_0001);
    chk("R12", "done_rd echo", r_rd, 5'd7);
    chk("R6", "LR request is a read", {r_write, r_size}, {1'b0, 2'd2});
    do_op(1, 2'd2, 64'h400, 64'hDEAD_BEEF_1234_5678, 5'd8, 0, 0, 0, 0);
    chk("R6", "SC word write data", r_wdata, 64'h0000_0000_1234_5678);
    chk("R6", "SC request write/size", {r_write, r_size}, {1'b1, 2'd2});
    chk("R5", "SC success result", {r_mem, r_exc, r_wb_en, r_wb}, {3'b101, 64'd0});
    do_op(1, 2'd2, 64'h400, 64'h1, 5'd8, 0, 0, 0, 0);
    chk("R5", "reservation dropped after success", {r_mem, r_wb_en, r_wb}, {2'b01, 64'd1});
  endtask

  task automatic t_sc_refused();
    do_op(0, 2'd3, 64'h800, 0, 5'd4, 0, 0, 64'h1122_3344_5566_7788, 0);
    chk("R8", "LR double unchanged", r_wb, 64'h1122_3344_5566_7788);
    do_op(1, 2'd3, 64'h800, 64'hCAFE_0000_0000_0001, 5'd5, 0, 1, 0, 0);
    chk("R6", "SC double full data", r_wdata, 64'hCAFE_0000_0000_0001);
    chk("R5", "SC refused result", {r_mem, r_wb_en, r_wb}, {2'b11, 64'd1});
    do_op(1, 2'd3, 64'h800, 0, 5'd5, 0, 0, 0, 0);
    chk("R5", "reservation dropped after refusal", {r_mem, r_wb}, {1'b0, 64'd1});
  endtask

  task automatic t_match();
    do_op(0, 2'd3, 64'h500, 0, 5'd1, 0, 0, 0, 0);
    do_op(1, 2'd2, 64'h500, 0, 5'd1, 0, 0, 0, 0);
    chk("R9", "size mismatch loses", {r_done, r_mem, r_wb}, {2'b10, 64'd1});
    do_op(0, 2'd2, 64'h600, 0, 5'd1, 0, 0, 0, 0);
    do_op(1, 2'd2, 64'h604, 0, 5'd1, 0, 0, 0, 0);
    chk("R4", "address mismatch loses", {r_done, r_mem, r_exc, r_wb_en, r_wb}, {4'b1001, 64'd1});
    do_op(1, 2'd2, 64'h600, 0, 5'd1, 0, 0, 0, 0);
    chk("R4", "reservation left invalid after miss", {r_mem, r_wb}, {1'b0, 64'd1});
  endtask

  task automatic t_inval();
    do_op(0, 2'd2, 64'h700, 0, 5'd1, 0, 0, 0, 0);
    @(negedge clk); resv_inval = 1'b1;
    @(negedge clk); resv_inval = 1'b0;
    do_op(1, 2'd2, 64'h700, 0, 5'd1, 0, 0, 0, 0);
    chk("R10", "invalidate drops reservation", {r_mem, r_wb}, {1'b0, 64'd1});
    do_op(0, 2'd2, 64'h700, 0, 5'd1, 0, 0, 0, 1);
    do_op(1, 2'd2, 64'h700, 0, 5'd1, 0, 0, 0, 0);
    chk("R10", "invalidate beats same-cycle LR", {r_mem, r_wb}, {1'b0, 64'd1});
  endtask

  task automatic t_fault();
    do_op(0, 2'd2, 64'h200, 0, 5'd6, 1, 0, 0, 0);
    chk("R3", "LR fault", {r_done, r_mem, r_exc, r_wb_en, r_cause}, {4'b1110, 5'd5});
    do_op(1, 2'd2, 64'h200, 0, 5'd6, 0, 0, 0, 0);
    chk("R3", "faulted LR sets no reservation", {r_mem, r_wb}, {1'b0, 64'd1});
    do_op(0, 2'd2, 64'h300, 0, 5'd6, 0, 0, 0, 0);
    do_op(1, 2'd2, 64'h300, 0, 5'd6, 1, 0, 0, 0);
    chk("R3", "SC fault", {r_done, r_mem, r_exc, r_wb_en, r_cause}, {4'b1110, 5'd7});
    do_op(1, 2'd2, 64'h300, 0, 5'd6, 0, 0, 0, 0);
    chk("R3", "SC fault keeps reservation", {r_mem, r_wb}, {1'b1, 64'd0});
  endtask

  task automatic t_xlen32();
    @(negedge clk); op32_valid = 1'b1;
    @(negedge clk); op32_valid = 1'b0;
    chk("R7", "doubleword illegal at XLEN 32", {d32v, d32e, d32wb, m32v, d32c}, {4'b1100, 5'd2});
    chk("R7", "unit idle after illegal", b32, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_align();
    t_sc_success();
    t_sc_refused();
    t_match();
    t_inval();
    t_fault();
    t_xlen32();
    repeat (2) @(negedge clk);
    summary();
  end
endmodule